// File: doc/BRIEF.md
# Handshaked Sensor Event Catcher

This block sits between a comparator output and a control state machine. The comparator level has already been synchronised upstream, but it is non-persistent: it may pulse for one clock and then vanish. The catcher turns that level into a clean four-phase request/acknowledge exchange. The controller raises `req`. The catcher then watches the sensor for the condition that the selected mode asks for. When the condition is met, it raises `ack` and keeps it high whatever the sensor does next. The controller ends the exchange by lowering `req`.

The mode is sampled once, in the cycle a new request is accepted, and then holds for the whole exchange. There are eight modes:

- **Level modes:** wait for high, wait for low, and a two-phase high-then-low wait.
- **Cancellable mode:** a wait for high that the controller may end early with `cancel`.
- **Edge modes:** wait for a true rising edge or a true falling edge.
- **Arbitration modes:** two modes that watch two sensors and report the winner on a dual-rail pair.

In the cancellable mode, `seen` tells the controller whether the exchange ended on a real event or on a cancellation. There is no data path, so `req`/`ack` is the only handshake and no valid/ready stream is used. All outputs are registered.

Top module: `lvl_catch`

## Requirements
- R1: After reset, `ack`, `seen`, `win_a` and `win_b` are 0.
  - With the condition already present, `ack` rises on the second rising clock edge after `req` is first sampled high.
  - In the plain modes, `ack` falls on the first edge that samples `req` low.
  - Lowering `req` before any event ends the exchange with no acknowledge.
- R2: Mode 0 (wait-high): a single-cycle high on `sense_a` sets `ack` and `seen`, and both stay high after `sense_a` returns low while `req` is held.
- R3: Mode 1 (wait-low) acknowledges a low on `sense_a`. A `sense_a` that stays high gives no acknowledge.
- R4: Mode 2 (two-phase): `ack` rises when `sense_a` is high. After `req` falls, `ack` stays high until `sense_a` is sampled low, and falls on that edge.
- R5: Mode 3 (cancellable wait-high):
  - `cancel` with no event completes the exchange with `ack`=1 and `seen`=0.
  - An event in the same cycle as `cancel` resolves as the event, with `seen`=1.
- R6: Mode 4 (rising edge) acknowledges only after `sense_a` has been seen low and then high during the wait. A sensor that is high throughout gives no acknowledge.
- R7: Mode 5 (falling edge) acknowledges only after `sense_a` has been seen high and then low during the wait. A sensor that starts low must first go high.
- R8: Mode 6 (arbitrate):
  - At most one of `win_a`/`win_b` is high, and a raised rail implies `ack`.
  - The sensor seen high first wins. A tie in one cycle goes to `sense_a`.
  - Both rails clear one edge after `req` falls.
- R9: Mode 7 (arbitrate, two-phase): arbitration is as in R8, but the winning rail and `ack` stay high after `req` falls until the winning sensor is sampled low.
- R10: `cancel` has no effect outside mode 3. In mode 0 with no event, `ack` stays 0 after a cancel pulse.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode | input | 3 | Behaviour select, sampled when a request is accepted (0..7 as in R2-R9) |
| req | input | 1 | Request from the controller (four-phase) |
| cancel | input | 1 | Withdraws a pending wait in mode 3 |
| sense_a | input | 1 | Synchronised comparator level A |
| sense_b | input | 1 | Synchronised comparator level B (arbitration modes only) |
| ack | output | 1 | Acknowledge to the controller |
| seen | output | 1 | 1 when the acknowledge came from a real event, 0 for a cancel |
| win_a | output | 1 | Dual-rail winner: sensor A |
| win_b | output | 1 | Dual-rail winner: sensor B |

## Verification
The hardest situations to reach from the ports involve timing against the wait itself:
- a sensor event that coincides with a cancel;
- an edge mode whose sensor already sits at the level the edge ends on;
- an arbitration where one sensor rises in an earlier cycle than the other.

Each table entry reaches these by holding a chosen "before" level on both sensors for one evaluation cycle of the wait. It then applies a one-cycle event pattern, with `cancel` where wanted, and returns the sensors to the "before" level. This shows both the capture and the latching. Directed sequences then cover the second phase of the two-phase modes, with the sensor still active after `req` has dropped.

// File: rtl/lvl_catch_pkg.sv
package lvl_catch_pkg;
  localparam int MODE_W = 3;
  localparam int ST_W   = 3;

  typedef enum logic [MODE_W-1:0] {
    M_HIGH  = 3'd0,
    M_LOW   = 3'd1,
    M_HILO  = 3'd2,
    M_CANHI = 3'd3,
    M_RISE  = 3'd4,
    M_FALL  = 3'd5,
    M_ARB   = 3'd6,
    M_ARB2  = 3'd7
  } mode_e;

  typedef enum logic [ST_W-1:0] {
    S_IDLE = 3'd0,
    S_WAIT = 3'd1,
    S_DONE = 3'd2,
    S_WLOW = 3'd3,
    S_REL  = 3'd4
  } state_e;
endpackage

// File: rtl/lvl_catch_edge.sv
// Edge qualifier: arms once the sensor shows the level an edge starts from,
// then fires when the opposite level follows, while the wait is active.
module lvl_catch_edge #(
  parameter bit RISING = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clear,
  input  logic active,
  input  logic sense,
  output logic fire
);
  logic armed;
  logic start_lvl;
  logic end_lvl;

  generate
    if (RISING) begin : g_rise
      assign start_lvl = ~sense;
      assign end_lvl   = sense;
    end else begin : g_fall
      assign start_lvl = sense;
      assign end_lvl   = ~sense;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rst_n)                   armed <= 1'b0;
    else if (clear)               armed <= 1'b0;
    else if (active && start_lvl) armed <= 1'b1;
  end

  assign fire = active & armed & end_lvl;
endmodule

// File: rtl/lvl_catch_arb.sv
// Two-input pick with a fixed tie-break.
module lvl_catch_arb #(
  parameter bit PRIO_A = 1'b1
) (
  input  logic in_a,
  input  logic in_b,
  output logic pick_a,
  output logic pick_b,
  output logic any
);
  generate
    if (PRIO_A) begin : g_prio_a
      assign pick_a = in_a;
      assign pick_b = in_b & ~in_a;
    end else begin : g_prio_b
      assign pick_a = in_a & ~in_b;
      assign pick_b = in_b;
    end
  endgenerate

  assign any = in_a | in_b;
endmodule

// File: rtl/lvl_catch_ctrl.sv
// Handshake sequencer: accepts a request, latches the mode, resolves the
// event (or a cancel) and runs the release phase the mode asks for.
module lvl_catch_ctrl
  import lvl_catch_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [MODE_W-1:0] mode,
  input  logic              req,
  input  logic              cancel,
  input  logic              sense_a,
  input  logic              sense_b,
  input  logic              rise_fire,
  input  logic              fall_fire,
  input  logic              pick_a,
  input  logic              pick_b,
  input  logic              any,
  output logic [MODE_W-1:0] mode_q,
  output logic              waiting,
  output logic              ack,
  output logic              seen,
  output logic              win_a,
  output logic              win_b
);
  state_e st;
  mode_e  md;
  logic   fire;
  logic   is_arb;
  logic   winner_low;

  assign md      = mode_e'(mode_q);
  assign waiting = (st == S_WAIT);
  assign is_arb  = (md == M_ARB) || (md == M_ARB2);

  always_comb begin
    unique case (md)
      M_HIGH, M_HILO, M_CANHI: fire = sense_a;
      M_LOW:                   fire = ~sense_a;
      M_RISE:                  fire = rise_fire;
      M_FALL:                  fire = fall_fire;
      default:                 fire = any;
    endcase
  end

  assign winner_low = (win_a && !sense_a) || (win_b && !sense_b);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st     <= S_IDLE;
      mode_q <= M_HIGH;
      ack    <= 1'b0;
      seen   <= 1'b0;
      win_a  <= 1'b0;
      win_b  <= 1'b0;
    end else begin
      unique case (st)
        S_IDLE: begin
          if (req) begin
            mode_q <= mode;
            st     <= S_WAIT;
          end
        end
        S_WAIT: begin
          if (fire) begin
            st   <= S_DONE;
            ack  <= 1'b1;
            seen <= 1'b1;
            if (is_arb) begin
              win_a <= pick_a;
              win_b <= pick_b;
            end
          end else if (cancel && md == M_CANHI) begin
            st   <= S_DONE;
            ack  <= 1'b1;
            seen <= 1'b0;
          end else if (!req) begin
            st <= S_IDLE;
          end
        end
        S_DONE: begin
          if (!req) begin
            if (md == M_HILO) begin
              st <= S_WLOW;
            end else if (md == M_ARB2) begin
              st <= S_REL;
            end else begin
              st    <= S_IDLE;
              ack   <= 1'b0;
              seen  <= 1'b0;
              win_a <= 1'b0;
              win_b <= 1'b0;
            end
          end
        end
        S_WLOW: begin
          if (!sense_a) begin
            st   <= S_IDLE;
            ack  <= 1'b0;
            seen <= 1'b0;
          end
        end
        S_REL: begin
          if (winner_low) begin
            st    <= S_IDLE;
            ack   <= 1'b0;
            seen  <= 1'b0;
            win_a <= 1'b0;
            win_b <= 1'b0;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/lvl_catch.sv
module lvl_catch
  import lvl_catch_pkg::*;
#(
  parameter bit ARB_PRIO_A = 1'b1
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [2:0] mode,
  input  logic       req,
  input  logic       cancel,
  input  logic       sense_a,
  input  logic       sense_b,
  output logic       ack,
  output logic       seen,
  output logic       win_a,
  output logic       win_b
);
  localparam int N_EDGE = 2;

  logic [MODE_W-1:0] mode_q;
  logic              waiting;
  logic [N_EDGE-1:0] edge_fire;
  logic [N_EDGE-1:0] edge_active;
  logic              pick_a, pick_b, any;

  // index 0: rising-edge unit, index 1: falling-edge unit
  generate
    for (genvar p = 0; p < N_EDGE; p++) begin : g_edge
      assign edge_active[p] = waiting &&
        (mode_q == ((p == 0) ? MODE_W'(M_RISE) : MODE_W'(M_FALL)));
      lvl_catch_edge #(.RISING(p == 0)) u_edge (
        .clk    (clk),
        .rst_n  (rst_n),
        .clear  (~waiting),
        .active (edge_active[p]),
        .sense  (sense_a),
        .fire   (edge_fire[p])
      );
    end
  endgenerate

  lvl_catch_arb #(.PRIO_A(ARB_PRIO_A)) u_arb (
    .in_a   (sense_a),
    .in_b   (sense_b),
    .pick_a (pick_a),
    .pick_b (pick_b),
    .any    (any)
  );

  lvl_catch_ctrl u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .mode      (mode),
    .req       (req),
    .cancel    (cancel),
    .sense_a   (sense_a),
    .sense_b   (sense_b),
    .rise_fire (edge_fire[0]),
    .fall_fire (edge_fire[1]),
    .pick_a    (pick_a),
    .pick_b    (pick_b),
    .any       (any),
    .mode_q    (mode_q),
    .waiting   (waiting),
    .ack       (ack),
    .seen      (seen),
    .win_a     (win_a),
    .win_b     (win_b)
  );
endmodule

// File: rtl/lvl_catch_chk.sv
module lvl_catch_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       req,
  input logic       cancel,
  input logic       sense_a,
  input logic       sense_b,
  input logic       ack,
  input logic       seen,
  input logic       win_a,
  input logic       win_b,
  input logic [2:0] mode_q
);
  a_r8_onehot_rails: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({win_a, win_b}));

  a_r8_rail_needs_ack: assert property (@(posedge clk) disable iff (!rst_n)
    (win_a || win_b) |-> ack);

  a_r2_ack_latched: assert property (@(posedge clk) disable iff (!rst_n)
    (ack && req) |=> ack);

  a_r5_cancel_origin: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(ack) && !seen) |-> $past(cancel));

  a_r9_release_a_low: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(win_a) && mode_q == 3'd7) |-> $past(!sense_a));

  a_r9_release_b_low: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(win_b) && mode_q == 3'd7) |-> $past(!sense_b));
endmodule

bind lvl_catch lvl_catch_chk u_lvl_catch_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .req     (req),
  .cancel  (cancel),
  .sense_a (sense_a),
  .sense_b (sense_b),
  .ack     (ack),
  .seen    (seen),
  .win_a   (win_a),
  .win_b   (win_b),
  .mode_q  (mode_q)
);

// File: tb/lvl_catch_bench.sv
`timescale 1ns/1ps
module lvl_catch_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [2:0] mode = 3'd0;
  logic       req = 1'b0, cancel = 1'b0, sense_a = 1'b0, sense_b = 1'b0;
  logic       ack, seen, win_a, win_b;
  int         runs = 0, fails = 0;
  bit         done = 1'b0;

  always #10 clk = ~clk;

  lvl_catch u_lvl_catch (
    .clk(clk), .rst_n(rst_n), .mode(mode), .req(req), .cancel(cancel),
    .sense_a(sense_a), .sense_b(sense_b),
    .ack(ack), .seen(seen), .win_a(win_a), .win_b(win_b)
  );

  // {mode[2:0], pre_a, pre_b, ev_a, ev_b, ev_cancel, ack, seen, win_a, win_b}
  localparam int NV = 19;
  localparam logic [11:0] VEC [NV] = '{
    12'b000_00_100_1100, 12'b000_00_000_0000, 12'b000_00_001_0000,
    12'b001_10_000_1100, 12'b001_10_100_0000, 12'b010_00_100_1100,
    12'b011_00_001_1000, 12'b011_00_101_1100, 12'b011_00_100_1100,
    12'b100_00_100_1100, 12'b100_10_100_0000, 12'b101_10_000_1100,
    12'b101_00_000_0000, 12'b110_00_100_1110, 12'b110_00_010_1101,
    12'b110_00_110_1110, 12'b110_01_110_1101, 12'b111_00_010_1101,
    12'b111_00_110_1110
  };

  function automatic string tag_of(logic [2:0] m, logic c);
    if (m == 3'd0 && c) return "R10";
    case (m)
      3'd0: return "R2";
      3'd1: return "R3";
      3'd2: return "R4";
      3'd3: return "R5";
      3'd4: return "R6";
      3'd5: return "R7";
      3'd6: return "R8";
      default: return "R9";
    endcase
  endfunction

  task automatic chk(string tag, logic [3:0] act, logic [3:0] exp);
    runs++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: {ack,seen,win_a,win_b} actual %b expected %b", tag, act, exp);
    end
  endtask

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic idle_out();
    req = 1'b0; cancel = 1'b0; sense_a = 1'b0; sense_b = 1'b0;
    tick(3);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("[TB] %0d tests run, %0d failed", runs, fails);
      $finish;
    end
  end

  initial begin
    // R1 reset state
    tick(3);
    chk("R1", {ack, seen, win_a, win_b}, 4'b0000);
    rst_n = 1'b1;
    tick(2);

    // Table walk: pre level for one evaluation, one-cycle event, back to pre
    for (int i = 0; i < NV; i++) begin
      logic [11:0] v;
      v = VEC[i];
      mode = v[11:9]; sense_a = v[8]; sense_b = v[7]; cancel = 1'b0; req = 1'b1;
      tick(2);
      sense_a = v[6]; sense_b = v[5]; cancel = v[4];
      tick(1);
      sense_a = v[8]; sense_b = v[7]; cancel = 1'b0;
      tick(2);
      chk(tag_of(v[11:9], v[4]), {ack, seen, win_a, win_b}, v[3:0]);
      req = 1'b0; sense_a = 1'b0; sense_b = 1'b0;
      tick(3);
      chk("R1", {ack, seen, win_a, win_b}, 4'b0000);
    end

    // R1 latency: condition present at request
    mode = 3'd0; sense_a = 1'b1; req = 1'b1;
    tick(1);
    chk("R1", {ack, seen, win_a, win_b}, 4'b0000);
    tick(1);
    chk("R1", {ack, seen, win_a, win_b}, 4'b1100);
    req = 1'b0;
    tick(1);
    chk("R1", {ack, seen, win_a, win_b}, 4'b0000);
    idle_out();

    // R4 second phase waits for low
    mode = 3'd2; sense_a = 1'b1; req = 1'b1;
    tick(2);
    req = 1'b0;
    tick(3);
    chk("R4", {ack, seen, win_a, win_b}, 4'b1100);
    sense_a = 1'b0;
    tick(1);
    chk("R4", {ack, seen, win_a, win_b}, 4'b0000);
    idle_out();

    // R9 winning rail held until winner low
    mode = 3'd7; sense_a = 1'b1; req = 1'b1;
    tick(2);
    req = 1'b0;
    tick(3);
    chk("R9", {ack, seen, win_a, win_b}, 4'b1110);
    sense_a = 1'b0;
    tick(1);
    chk("R9", {ack, seen, win_a, win_b}, 4'b0000);
    idle_out();

    // R8 plain arbitration releases with req even if winner still high
    mode = 3'd6; sense_a = 1'b1; req = 1'b1;
    tick(2);
    chk("R8", {ack, seen, win_a, win_b}, 4'b1110);
    req = 1'b0;
    tick(1);
    chk("R8", {ack, seen, win_a, win_b}, 4'b0000);
    idle_out();

    // R7 falling edge from a low start: low, high, low
    mode = 3'd5; sense_a = 1'b0; req = 1'b1;
    tick(3);
    chk("R7", {ack, seen, win_a, win_b}, 4'b0000);
    sense_a = 1'b1;
    tick(1);
    chk("R7", {ack, seen, win_a, win_b}, 4'b0000);
    sense_a = 1'b0;
    tick(1);
    chk("R7", {ack, seen, win_a, win_b}, 4'b1100);
    idle_out();

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", runs, fails);
    $finish;
  end
endmodule